// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Main Divider

This block divides a fast input clock by a programmable ratio using the pulse-swallow method. A behavioural dual-modulus prescaler divides by 64 or by 65. A swallow counter holds it in the divide-by-65 mode for the first A prescaler cycles of every output period. A main counter then closes the period after B prescaler cycles in total. The overall ratio is therefore N = 64·B + A input cycles per output pulse.

The A and B settings come from a main-divider register that is loaded elsewhere. The block samples them only at a period boundary, and the first boundary is the first clock edge after reset is released. A period already in progress is never shortened or stretched by a change of setting.

A setting that breaks the range rules raises a sticky flag, and the flag holds the output pulse low until the next reset. The modulus-control signal is brought out to a port so that the prescaler mode can be observed in each cycle.

Top module: `pswal_divider`

## Requirements
- R1: While reset is held low, `pulse_out`, `mod_sel` and `cfg_bad` are all 0.
- R2: For a legal setting, `pulse_out` rises once every N = 64·B + A input clock cycles.
- R3: After reset is released, the first clock edge loads the setting, and the first `pulse_out` is high in the cycle that follows edge N+1.
- R4: `mod_sel` is 1 (prescaler divides by 65) for exactly 65·A cycles of each period, all at the start of the period, and is 0 for the remaining 64·(B−A) cycles.
- R5: With B = 260 and A = 32 the period is 16672 cycles. With B = 99 and A = 12 the period is 6348 cycles.
- R6: A new A or B value applied in the middle of a period leaves the length of that period unchanged. It takes effect from the next period.
- R7: A setting with B < 3 that is sampled at a boundary sets `cfg_bad`.
- R8: A setting with A ≥ 64 that is sampled at a boundary sets `cfg_bad`.
- R9: A setting with A ≥ B that is sampled at a boundary sets `cfg_bad`. A setting with B ≥ 3 and A < min(64, B) leaves it at 0.
- R10: Once `cfg_bad` is set, it stays set until reset, even if a legal setting is applied later. While it is set, `pulse_out` stays 0, including at the boundary where the flag is raised.
- R11: `pulse_out` is high for exactly one input cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_set | input | 7 | Swallow count A from the main-divider register |
| b_set | input | 11 | Main count B from the main-divider register |
| pulse_out | output | 1 | One-cycle pulse at the comparison rate |
| mod_sel | output | 1 | Modulus control: 1 selects divide-by-65, 0 selects divide-by-64 |
| cfg_bad | output | 1 | Sticky flag for an illegal A/B setting |

## Verification
The single-cycle pulse property assumes that any legal ratio is far longer than two cycles. This follows from B ≥ 3, and an illegal setting silences the output altogether. The modulus-steadiness check assumes that `mod_sel` can change only at a prescaler terminal count or at a reload, so the stimulus changes A and B only between clock edges and never forces internal state. The reload check assumes that the inputs are sampled only at the boundary edge. For this reason the mid-period change test applies its new values well away from a boundary, and each illegal-setting test starts from a reset so that the sticky flag begins cleared.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } modulus_e;

  // Overall division ratio of a dual-modulus divider with base modulus p.
  function automatic int unsigned ratio_of(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned p);
    return p * b + a;
  endfunction

  // Range rules: B at least min_b, A below the prescaler modulus and below B.
  function automatic logic setting_ok(input int unsigned a,
                                      input int unsigned b,
                                      input int unsigned p,
                                      input int unsigned min_b);
    return (b >= min_b) && (a < p) && (a < b);
  endfunction

endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
  parameter int PW = 6
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic restart,
  input  logic plus_one,
  output logic pre_tc
);
  localparam int PMOD = 2 ** PW;
  localparam logic [PW:0] LAST_BASE  = (PW+1)'(PMOD - 1);
  localparam logic [PW:0] LAST_PLUS1 = (PW+1)'(PMOD);

  logic [PW:0] phase_q;
  logic [PW:0] last_phase;

  assign last_phase = plus_one ? LAST_PLUS1 : LAST_BASE;
  assign pre_tc     = (phase_q == last_phase);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (restart || pre_tc) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  // R2: the phase never leaves the range of the current modulus
  a_r2_phase_bound: assert property (@(posedge clk_in) disable iff (!rst_n)
    (phase_q <= LAST_PLUS1) && (plus_one || (phase_q <= LAST_BASE)));

endmodule

// File: rtl/pswal_swallow.sv
module pswal_swallow #(
  parameter int AW = 7
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic          swallowing
);
  logic [AW-1:0] a_rem_q;

  assign swallowing = (a_rem_q != '0);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)                  a_rem_q <= '0;
    else if (load)               a_rem_q <= load_val;
    else if (step && swallowing) a_rem_q <= a_rem_q - 1'b1;
  end

  // R4: between reloads the remaining swallow count never grows
  a_r4_swallow_down: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$past(load) |-> (a_rem_q <= $past(a_rem_q)));

endmodule

// File: rtl/pswal_maincount.sv
module pswal_maincount #(
  parameter int BW = 11
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  input  logic          step,
  output logic          period_end
);
  localparam logic [BW-1:0] LAST_CYCLE = BW'(1);

  logic [BW-1:0] b_rem_q;

  assign period_end = step && (b_rem_q == LAST_CYCLE);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)    b_rem_q <= '0;
    else if (load) b_rem_q <= load_val;
    else if (step) b_rem_q <= b_rem_q - 1'b1;
  end

  // R6: the main count reloads from the value presented at the boundary
  a_r6_reload: assert property (@(posedge clk_in) disable iff (!rst_n)
    load |=> (b_rem_q == $past(load_val)));

endmodule

// File: rtl/pswal_divider.sv
module pswal_divider #(
  parameter int PW    = 6,
  parameter int AW    = 7,
  parameter int BW    = 11,
  parameter int MIN_B = 3
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic [AW-1:0] a_set,
  input  logic [BW-1:0] b_set,
  output logic          pulse_out,
  output logic          mod_sel,
  output logic          cfg_bad
);
  import pswal_pkg::*;

  localparam int PMOD = 2 ** PW;

  logic     start_q;
  logic     boundary;
  logic     pre_tc;
  logic     period_end;
  logic     swallowing;
  logic     setting_legal;
  logic     load_bad;
  logic     pulse_q;
  logic     bad_q;
  modulus_e modulus;

  assign boundary      = start_q || period_end;
  assign setting_legal = setting_ok(int'(a_set), int'(b_set), PMOD, MIN_B);
  assign load_bad      = boundary && !setting_legal;
  assign modulus       = swallowing ? MOD_PLUS1 : MOD_BASE;

  pswal_prescaler #(.PW(PW)) u_presc (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .restart  (boundary),
    .plus_one (modulus == MOD_PLUS1),
    .pre_tc   (pre_tc)
  );

  pswal_swallow #(.AW(AW)) u_swallow (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .load       (boundary),
    .load_val   (a_set),
    .step       (pre_tc),
    .swallowing (swallowing)
  );

  pswal_maincount #(.BW(BW)) u_main (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .load       (boundary),
    .load_val   (b_set),
    .step       (pre_tc),
    .period_end (period_end)
  );

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      pulse_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      pulse_q <= period_end && !bad_q && !load_bad;
      bad_q   <= bad_q || load_bad;
    end
  end

  assign pulse_out = pulse_q;
  assign cfg_bad   = bad_q;
  assign mod_sel   = (modulus == MOD_PLUS1);

  // R10: the flag never clears without a reset
  a_r10_flag_sticky: assert property (@(posedge clk_in) disable iff (!rst_n)
    cfg_bad |=> cfg_bad);

  // R10: no pulse while the flag is set
  a_r10_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
    cfg_bad |-> !pulse_out);

  // R11: a pulse lasts one cycle
  a_r11_single_cycle: assert property (@(posedge clk_in) disable iff (!rst_n)
    pulse_out |=> !pulse_out);

  // R4: the modulus changes only at a prescaler terminal count or a reload
  a_r4_mod_steady: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!$past(boundary) && !$past(pre_tc)) |-> $stable(mod_sel));

endmodule

// File: tb/pswal_divider_tb.sv
`timescale 1ns/1ps
module pswal_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  a_in = '0;
  logic [10:0] b_in = 11'd3;
  logic        pulse_out, mod_sel, cfg_bad;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pswal_divider u_dut (
    .clk_in    (clk),
    .rst_n     (rst_n),
    .a_set     (a_in),
    .b_set     (b_in),
    .pulse_out (pulse_out),
    .mod_sel   (mod_sel),
    .cfg_bad   (cfg_bad)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int a, input int b);
    rst_n = 1'b0;
    a_in  = 7'(a);
    b_in  = 11'(b);
    repeat (3) @(negedge clk);
    check(!pulse_out && !mod_sel && !cfg_bad, "R1 reset state",
          int'({pulse_out, mod_sel, cfg_bad}), 0);
    rst_n = 1'b1;
  endtask

  // Count edges from now until pulse_out is seen high.
  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (pulse_out) break;
    end
  endtask

  // Called at a negedge with pulse_out high: measure one full period.
  task automatic measure_period(input int limit, output int n, output int m);
    m = mod_sel ? 1 : 0;
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (pulse_out) break;
      m += mod_sel ? 1 : 0;
    end
  endtask

  task automatic run_legal(input int a, input int b, input string req);
    int n_exp, n, m;
    n_exp = 64 * b + a;
    do_reset(a, b);
    wait_pulse(n_exp + 10, n);
    check(n == n_exp + 1, "R3 first pulse latency", n, n_exp + 1);
    measure_period(n_exp + 10, n, m);
    check(n == n_exp, req, n, n_exp);
    check(m == 65 * a, "R4 divide-by-65 cycles", m, 65 * a);
    check(!cfg_bad, "R9 legal setting keeps flag clear", int'(cfg_bad), 0);
    @(negedge clk);
    check(!pulse_out, "R11 pulse width", int'(pulse_out), 0);
  endtask

  task automatic run_illegal(input int a, input int b, input string req);
    int pulses;
    pulses = 0;
    do_reset(a, b);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      pulses += pulse_out ? 1 : 0;
    end
    check(cfg_bad, req, int'(cfg_bad), 1);
    check(pulses == 0, "R10 no pulse while flagged", pulses, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, m, pulses;
    @(negedge clk);
    // R2: sweep every legal A for the smallest B values
    for (int b = 3; b <= 5; b++)
      for (int a = 0; a < b; a++)
        run_legal(a, b, "R2 period length");
    run_legal(63, 64, "R2 period with largest A");
    run_legal(32, 260, "R5 example 16672");
    run_legal(12, 99, "R5 example 6348");

    // R6: change the setting in mid-period
    do_reset(1, 3);
    wait_pulse(300, n);
    repeat (20) @(negedge clk);
    a_in = 7'd2; b_in = 11'd4;
    wait_pulse(400, n);
    check(n + 20 == 193, "R6 current period unchanged", n + 20, 193);
    measure_period(400, n, m);
    check(n == 258, "R6 new period length", n, 258);
    check(m == 130, "R6 new divide-by-65 cycles", m, 130);

    run_illegal(0, 2, "R7 B below 3 flagged");
    run_illegal(64, 100, "R8 A at 64 flagged");
    run_illegal(5, 5, "R9 A equal to B flagged");

    // R10: flag survives a later legal setting
    a_in = 7'd1; b_in = 11'd3;
    pulses = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      pulses += pulse_out ? 1 : 0;
    end
    check(cfg_bad, "R10 flag sticky", int'(cfg_bad), 1);
    check(pulses == 0, "R10 no pulse after legal setting", pulses, 0);

    // R9 and R10: illegal setting applied while running
    do_reset(0, 3);
    wait_pulse(300, n);
    repeat (5) @(negedge clk);
    a_in = 7'd3; b_in = 11'd3;
    pulses = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pulses += pulse_out ? 1 : 0;
    end
    check(cfg_bad, "R9 flag raised at boundary", int'(cfg_bad), 1);
    check(pulses == 0, "R10 boundary pulse suppressed", pulses, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule